// File: doc/BRIEF.md
# Wakeup Interrupt Sense Converter

This block sits between a bank of raw interrupt sources and a downstream interrupt controller that only understands active-high levels and rising edges. Each source line has its own enable bit and a 3-bit sense code. The block reshapes every enabled line into the form the controller expects. An active-low level comes out inverted. A falling edge, a rising edge or either edge comes out as a single-cycle high pulse. A disabled line, or one with an unassigned sense code, stays low.

Raw inputs are asynchronous. They pass through a two-flop synchronizer before any edge detection. Software programs the block through a word-addressed register port. A write takes effect on the clock edge that samples it, and read data is registered one cycle after the read strobe. Software is expected to keep a line disabled while it rewrites that line's sense code. Changing the code on a live line can produce a spurious output assertion.

Each line runs a four-state machine:
- `LS_OFF`: output low, edge history cleared.
- `LS_LEVEL`: output follows the synchronized input, inverted for active-low.
- `LS_ARM`: output low; this one cycle loads the edge history from the input.
- `LS_EDGE`: the output pulses on the selected transitions.

The transitions are:
- `go_level`: any state moves to `LS_LEVEL` when the line is enabled with a level code.
- `go_arm`: `LS_OFF` or `LS_LEVEL` moves to `LS_ARM` when the line is enabled with an edge code.
- `go_edge`: `LS_ARM` or `LS_EDGE` moves to `LS_EDGE` while the line is enabled with an edge code.
- `go_off`: any state moves to `LS_OFF` when the line is disabled or its code is unassigned.

Top module: `wake_sense_conv`

## Requirements
- R1: After reset every enable bit and every sense code is zero, all outputs are low, and `rdata` is zero.
- R2: Line n has its enable bit at bit n%32 of the word at byte address 0x10 + 4*(n/32). Enable bits beyond the last line read as zero. An access to an address that is not a multiple of four has no effect and reads zero.
- R3: Line n has its sense code in bits [2:0] of the word at byte address 0x110 + 4*n. The upper bits of that word read as zero. Addresses past the last line, and addresses outside both windows, read zero and ignore writes.
- R4: With sense code 3'b100 (level, active high), the output equals the input delayed by two clock edges.
- R5: With sense code 3'b000 (level, active low), the output equals the inverted input delayed by two clock edges.
- R6: With sense code 3'b110 (rising edge), each low-to-high input transition gives exactly one single-cycle output pulse. A high-to-low transition gives none.
- R7: With sense code 3'b010 (falling edge), each high-to-low input transition gives exactly one single-cycle output pulse. A low-to-high transition gives none.
- R8: With sense code 3'b111 (both edges), every input transition gives one single-cycle output pulse.
- R9: A disabled line, or a line whose code is 3'b001, 3'b011 or 3'b101, keeps its output low. When an edge-mode line is enabled, it spends its first cycle arming its edge history with no output. An input already high at that point therefore produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Raw asynchronous interrupt sources |
| irq_out | output | NUM_LINES | Converted active-high / rising outputs, one per source |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the register word |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid the cycle after `rd_en` |

## Verification
The assertions assume that a line's sense code only changes while that line is disabled. Under that assumption a line's current code also describes the mode its state machine entered on the previous edge. Both the random and the directed stimulus write a sense code only to a line whose enable bit has already been cleared. They set the enable bit only with a later write, and they never toggle inputs while a register access is in flight. A reference model in the bench tracks the synchronizer and each line's mode. Its predicted outputs are compared on every cycle, and readback values are computed from the same model.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

    localparam int SENSE_W = 3;

    localparam logic [SENSE_W-1:0] SNS_LVL_LO = 3'b000;
    localparam logic [SENSE_W-1:0] SNS_FALL   = 3'b010;
    localparam logic [SENSE_W-1:0] SNS_LVL_HI = 3'b100;
    localparam logic [SENSE_W-1:0] SNS_RISE   = 3'b110;
    localparam logic [SENSE_W-1:0] SNS_BOTH   = 3'b111;

    typedef enum logic [1:0] {
        LS_OFF   = 2'd0,
        LS_LEVEL = 2'd1,
        LS_ARM   = 2'd2,
        LS_EDGE  = 2'd3
    } line_state_e;

    function automatic logic sense_is_level(input logic [SENSE_W-1:0] s);
        return (s == SNS_LVL_LO) || (s == SNS_LVL_HI);
    endfunction

    function automatic logic sense_is_edge(input logic [SENSE_W-1:0] s);
        return (s == SNS_FALL) || (s == SNS_RISE) || (s == SNS_BOTH);
    endfunction

endpackage

// File: rtl/wsc_sync.sv
module wsc_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/wsc_regs.sv
module wsc_regs
    import wsc_pkg::*;
#(
    parameter int NUM_LINES = 168,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 12,
    parameter int EN_BASE   = 'h010,
    parameter int CFG_BASE  = 'h110
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic                           rd_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              wdata,
    output logic [DATA_W-1:0]              rdata,
    output logic [NUM_LINES-1:0]           en_o,
    output logic [NUM_LINES*SENSE_W-1:0]   cfg_o
);
    localparam int EN_WORDS = (NUM_LINES + DATA_W - 1) / DATA_W;
    localparam int WIDX_W   = ADDR_W - 2;
    localparam logic [WIDX_W-1:0] EN_BASE_W  = WIDX_W'(EN_BASE / 4);
    localparam logic [WIDX_W-1:0] CFG_BASE_W = WIDX_W'(CFG_BASE / 4);
    localparam logic [WIDX_W-1:0] EN_CNT_W   = WIDX_W'(EN_WORDS);
    localparam logic [WIDX_W-1:0] CFG_CNT_W  = WIDX_W'(NUM_LINES);

    logic                       aligned;
    logic [WIDX_W-1:0]          widx, en_rel, cfg_rel;
    logic                       en_hit, cfg_hit;
    logic [EN_WORDS*DATA_W-1:0] en_flat;
    logic [DATA_W-1:0]          rd_val;

    assign aligned = (addr[1:0] == 2'b00);
    assign widx    = addr[ADDR_W-1:2];
    assign en_rel  = widx - EN_BASE_W;
    assign cfg_rel = widx - CFG_BASE_W;
    assign en_hit  = aligned && (widx >= EN_BASE_W)  && (en_rel  < EN_CNT_W);
    assign cfg_hit = aligned && (widx >= CFG_BASE_W) && (cfg_rel < CFG_CNT_W);

    generate
        for (genvar k = 0; k < EN_WORDS; k++) begin : g_en_word
            localparam int REM   = NUM_LINES - k * DATA_W;
            localparam int VALID = (REM >= DATA_W) ? DATA_W : REM;
            localparam logic [DATA_W-1:0] WMASK = (VALID == DATA_W) ? {DATA_W{1'b1}}
                                                : ((DATA_W'(1) << VALID) - DATA_W'(1));
            logic [DATA_W-1:0] word_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    word_q <= '0;
                end else if (wr_en && en_hit && (en_rel == WIDX_W'(k))) begin
                    word_q <= wdata & WMASK;
                end
            end
            assign en_flat[k*DATA_W +: DATA_W] = word_q;
        end

        for (genvar i = 0; i < NUM_LINES; i++) begin : g_cfg
            logic [SENSE_W-1:0] code_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    code_q <= '0;
                end else if (wr_en && cfg_hit && (cfg_rel == WIDX_W'(i))) begin
                    code_q <= wdata[SENSE_W-1:0];
                end
            end
            assign cfg_o[i*SENSE_W +: SENSE_W] = code_q;
        end
    endgenerate

    assign en_o = en_flat[NUM_LINES-1:0];

    always_comb begin
        rd_val = '0;
        for (int k = 0; k < EN_WORDS; k++) begin
            if (en_hit && (en_rel == WIDX_W'(k))) rd_val = en_flat[k*DATA_W +: DATA_W];
        end
        for (int i = 0; i < NUM_LINES; i++) begin
            if (cfg_hit && (cfg_rel == WIDX_W'(i))) begin
                rd_val = {{(DATA_W-SENSE_W){1'b0}}, cfg_o[i*SENSE_W +: SENSE_W]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_val;
    end
endmodule

// File: rtl/wsc_line.sv
module wsc_line
    import wsc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [SENSE_W-1:0] sense,
    input  logic               din,
    output logic               irq_o
);
    line_state_e state_q, state_d;
    logic        hist_q;
    logic        want_level, want_edge;

    assign want_level = en && sense_is_level(sense);
    assign want_edge  = en && sense_is_edge(sense);

    // next-state: go_level, go_arm, go_edge, go_off
    always_comb begin
        state_d = LS_OFF;
        unique case (state_q)
            LS_OFF, LS_LEVEL: begin
                if (want_level)     state_d = LS_LEVEL;
                else if (want_edge) state_d = LS_ARM;
                else                state_d = LS_OFF;
            end
            LS_ARM, LS_EDGE: begin
                if (want_level)     state_d = LS_LEVEL;
                else if (want_edge) state_d = LS_EDGE;
                else                state_d = LS_OFF;
            end
            default: state_d = LS_OFF;
        endcase
    end

    // state register with edge history; history is cleared while off
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LS_OFF;
            hist_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            hist_q  <= (state_q == LS_OFF) ? 1'b0 : din;
        end
    end

    // outputs
    always_comb begin
        irq_o = 1'b0;
        unique case (state_q)
            LS_OFF, LS_ARM: irq_o = 1'b0;
            LS_LEVEL:       irq_o = (sense == SNS_LVL_LO) ? ~din : din;
            LS_EDGE: begin
                case (sense)
                    SNS_RISE: irq_o =  din & ~hist_q;
                    SNS_FALL: irq_o = ~din &  hist_q;
                    SNS_BOTH: irq_o =  din ^  hist_q;
                    default:  irq_o = 1'b0;
                endcase
            end
            default: irq_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/wake_sense_conv.sv
module wake_sense_conv
    import wsc_pkg::*;
#(
    parameter int NUM_LINES = 168,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 12,
    parameter int EN_BASE   = 'h010,
    parameter int CFG_BASE  = 'h110
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic [NUM_LINES-1:0] irq_out,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata
);
    localparam int CFG_BITS = NUM_LINES * SENSE_W;

    logic [NUM_LINES-1:0] en_vec;
    logic [NUM_LINES-1:0] irq_sync;
    logic [CFG_BITS-1:0]  cfg_flat;

    wsc_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (2)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (irq_in),
        .q     (irq_sync)
    );

    wsc_regs #(
        .NUM_LINES (NUM_LINES),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .EN_BASE   (EN_BASE),
        .CFG_BASE  (CFG_BASE)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .en_o  (en_vec),
        .cfg_o (cfg_flat)
    );

    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
            wsc_line u_line (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (en_vec[g]),
                .sense (cfg_flat[g*SENSE_W +: SENSE_W]),
                .din   (irq_sync[g]),
                .irq_o (irq_out[g])
            );
        end
    endgenerate
endmodule

// File: rtl/wsc_checker.sv
module wsc_checker
    import wsc_pkg::*;
#(
    parameter int NUM_LINES = 168
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NUM_LINES-1:0]           irq_in,
    input logic [NUM_LINES-1:0]           irq_out,
    input logic [NUM_LINES-1:0]           en_vec,
    input logic [NUM_LINES*SENSE_W-1:0]   cfg_flat
);
    logic [NUM_LINES-1:0] lvh, lvl, one_dir, edge_cls;

    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_cls
            logic [SENSE_W-1:0] s;
            assign s           = cfg_flat[g*SENSE_W +: SENSE_W];
            assign lvh[g]      = en_vec[g] && (s == SNS_LVL_HI);
            assign lvl[g]      = en_vec[g] && (s == SNS_LVL_LO);
            assign one_dir[g]  = en_vec[g] && ((s == SNS_RISE) || (s == SNS_FALL));
            assign edge_cls[g] = sense_is_edge(s);
        end
    endgenerate

    p_level_high_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_out ^ $past(irq_in, 2)) & $past(lvh)) == '0);

    p_level_low_invert_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_out ^ ~$past(irq_in, 2)) & $past(lvl)) == '0);

    // R6 and R7: single-direction edge modes never pulse two cycles running
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & $past(irq_out) & one_dir & $past(one_dir)) == '0);

    p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & ~en_vec & ~$past(en_vec)) == '0);

    p_arm_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & $past(en_vec) & ~$past(en_vec, 2) & $past(edge_cls)) == '0);
endmodule

bind wake_sense_conv wsc_checker #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .irq_out  (irq_out),
    .en_vec   (en_vec),
    .cfg_flat (cfg_flat)
);

// File: tb/sim_wake_sense_conv.sv
module sim_wake_sense_conv;
    localparam int N   = 168;
    localparam int AW  = 12;
    localparam int DW  = 32;
    localparam int ENW = (N + 31) / 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic [N-1:0]  irq_out;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;

    always #10 clk = ~clk;

    wake_sense_conv #(.NUM_LINES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_out(irq_out),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int cyc = 0;

    // ---------------- reference model ----------------
    logic [N-1:0] m_s1, m_s2, m_hist, m_en;
    logic [2:0]   m_cfg  [N];
    logic [1:0]   m_mode [N];   // 0 off, 1 level, 2 arming, 3 edge

    function automatic bit is_lvl(input logic [2:0] c);
        return (c == 3'b000) || (c == 3'b100);
    endfunction
    function automatic bit is_edg(input logic [2:0] c);
        return (c == 3'b010) || (c == 3'b110) || (c == 3'b111);
    endfunction
    function automatic logic [1:0] nxt_mode(input logic [1:0] m, input logic e, input logic [2:0] c);
        if (e && is_lvl(c)) return 2'd1;
        if (e && is_edg(c)) return (m >= 2'd2) ? 2'd3 : 2'd2;
        return 2'd0;
    endfunction
    function automatic logic exp_line(input logic [1:0] m, input logic s, input logic h, input logic [2:0] c);
        if (m == 2'd1) return (c == 3'b000) ? ~s : s;
        if (m == 2'd3) begin
            if (c == 3'b110) return s & ~h;
            if (c == 3'b010) return ~s & h;
            if (c == 3'b111) return s ^ h;
        end
        return 1'b0;
    endfunction
    function automatic string rtag(input logic [1:0] m, input logic [2:0] c);
        if (m == 2'd0 || m == 2'd2) return "R9";
        case (c)
            3'b100: return "R4";
            3'b000: return "R5";
            3'b110: return "R6";
            3'b010: return "R7";
            3'b111: return "R8";
            default: return "R9";
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_hist <= '0; m_en <= '0;
            for (int i = 0; i < N; i++) begin m_cfg[i] <= 3'b000; m_mode[i] <= 2'd0; end
        end else begin
            m_s1 <= irq_in;
            m_s2 <= m_s1;
            for (int i = 0; i < N; i++) begin
                m_hist[i] <= (m_mode[i] == 2'd0) ? 1'b0 : m_s2[i];
                m_mode[i] <= nxt_mode(m_mode[i], m_en[i], m_cfg[i]);
            end
            if (wr_en && addr[1:0] == 2'b00) begin
                if (int'(addr) >= 'h10 && int'(addr) < 'h10 + 4*ENW) begin
                    for (int b = 0; b < 32; b++) begin
                        if ((int'(addr) - 'h10) / 4 * 32 + b < N)
                            m_en[(int'(addr) - 'h10) / 4 * 32 + b] <= wdata[b];
                    end
                end else if (int'(addr) >= 'h110 && int'(addr) < 'h110 + 4*N) begin
                    m_cfg[(int'(addr) - 'h110) / 4] <= wdata[2:0];
                end
            end
        end
    end

    function automatic logic [31:0] exp_rd(input int a);
        logic [31:0] v;
        v = '0;
        if (a % 4 != 0) return v;
        if (a >= 'h10 && a < 'h10 + 4*ENW) begin
            for (int b = 0; b < 32; b++)
                if ((a - 'h10) / 4 * 32 + b < N) v[b] = m_en[(a - 'h10) / 4 * 32 + b];
        end else if (a >= 'h110 && a < 'h110 + 4*N) begin
            v[2:0] = m_cfg[(a - 'h110) / 4];
        end
        return v;
    endfunction

    // continuous output comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [N-1:0] e;
            int first;
            first = -1;
            for (int i = 0; i < N; i++) begin
                e[i] = exp_line(m_mode[i], m_s2[i], m_hist[i], m_cfg[i]);
                if (first < 0 && e[i] !== irq_out[i]) first = i;
            end
            total++;
            if (first >= 0) begin
                bad++;
                $display("FAIL %s line %0d irq_out=%b expected=%b", rtag(m_mode[first], m_cfg[first]),
                         first, irq_out[first], e[first]);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int a);
        logic [31:0] e;
        e = exp_rd(a);
        @(negedge clk);
        rd_en = 1'b1; addr = AW'(a);
        @(negedge clk);
        rd_en = 1'b0;
        chk(tag, rdata, e);
    endtask

    task automatic set_en(input int line, input logic v);
        logic [31:0] w;
        w = exp_rd('h10 + 4 * (line / 32));
        w[line % 32] = v;
        wr('h10 + 4 * (line / 32), w);
    endtask

    task automatic set_cfg(input int line, input logic [2:0] c);
        wr('h110 + 4 * line, {29'd0, c});
    endtask

    task automatic count_pulses(input int line, input int cycles, input bit toggle, output int n);
        n = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (toggle && k % 3 == 0) irq_in[line] = ~irq_in[line];
            n += int'(irq_out[line]);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int n;
        logic [2:0] codes [8];
        codes = '{3'b000, 3'b010, 3'b100, 3'b110, 3'b111, 3'b001, 3'b011, 3'b101};
        void'($urandom(32'h5eed_1234));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq_out", 32'(irq_out != '0), 32'd0);
        chk("R1 rdata", rdata, 32'd0);
        rd_chk("R1 enable word", 'h10);
        rd_chk("R1 sense word", 'h110);

        // R2: enable map, padding bits, unaligned access
        wr('h10 + 4*5, 32'hFFFF_FFFF);
        rd_chk("R2 last enable word padding", 'h10 + 4*5);
        chk("R2 model padding", exp_rd('h10 + 4*5), 32'h0000_00FF);
        wr('h10 + 4*5, 32'h0);
        wr('h12, 32'hFFFF_FFFF);
        rd_chk("R2 unaligned write ignored", 'h10);
        rd_chk("R2 unaligned read zero", 'h12);

        // R3: sense words, upper bits, out of range
        set_cfg(167, 3'b110);
        wr('h110 + 4*167, 32'hFFFF_FFF6);
        rd_chk("R3 last sense word", 'h110 + 4*167);
        chk("R3 model upper bits", exp_rd('h110 + 4*167), 32'd6);
        wr('h110 + 4*N, 32'h7);
        rd_chk("R3 past last line", 'h110 + 4*N);
        rd_chk("R3 gap address", 'h100);
        set_cfg(167, 3'b000);

        // R4: level active high on line 3
        set_cfg(3, 3'b100);
        set_en(3, 1'b1);
        @(negedge clk); irq_in[3] = 1'b1;
        @(negedge clk); chk("R4 one edge later", 32'(irq_out[3]), 32'd0);
        @(negedge clk); chk("R4 two edges later", 32'(irq_out[3]), 32'd1);

        // R5: level active low on line 4
        set_cfg(4, 3'b000);
        set_en(4, 1'b1);
        repeat (2) @(negedge clk);
        chk("R5 low input high output", 32'(irq_out[4]), 32'd1);
        irq_in[4] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R5 high input low output", 32'(irq_out[4]), 32'd0);

        // R6: rising edge on line 33
        set_cfg(33, 3'b110);
        set_en(33, 1'b1);
        irq_in[33] = 1'b1;
        count_pulses(33, 6, 1'b0, n); chk("R6 rise pulses", n, 1);
        irq_in[33] = 1'b0;
        count_pulses(33, 6, 1'b0, n); chk("R6 fall ignored", n, 0);

        // R7: falling edge on line 34
        set_cfg(34, 3'b010);
        set_en(34, 1'b1);
        irq_in[34] = 1'b1;
        count_pulses(34, 6, 1'b0, n); chk("R7 rise ignored", n, 0);
        irq_in[34] = 1'b0;
        count_pulses(34, 6, 1'b0, n); chk("R7 fall pulses", n, 1);

        // R8: both edges on line 35
        set_cfg(35, 3'b111);
        set_en(35, 1'b1);
        irq_in[35] = 1'b1;
        count_pulses(35, 6, 1'b0, n); chk("R8 rise pulses", n, 1);
        irq_in[35] = 1'b0;
        count_pulses(35, 6, 1'b0, n); chk("R8 fall pulses", n, 1);

        // R9: arming with input already high, unassigned code, disabled line
        irq_in[40] = 1'b1;
        set_cfg(40, 3'b110);
        repeat (4) @(negedge clk);
        set_en(40, 1'b1);
        count_pulses(40, 6, 1'b0, n); chk("R9 no stale edge", n, 0);
        set_cfg(41, 3'b101);
        set_en(41, 1'b1);
        count_pulses(41, 12, 1'b1, n); chk("R9 unassigned code quiet", n, 0);
        set_cfg(42, 3'b111);
        count_pulses(42, 12, 1'b1, n); chk("R9 disabled line quiet", n, 0);

        // random phase; sense codes change only on disabled lines
        for (int it = 0; it < 4000; it++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++)
                if ($urandom % 8 == 0) irq_in[i] = ~irq_in[i];
            if ($urandom % 10 == 0) begin
                int line;
                line = int'($urandom % N);
                if (m_en[line]) begin
                    set_en(line, 1'b0);
                end else begin
                    set_cfg(line, codes[$urandom % 8]);
                    set_en(line, 1'b1);
                end
            end
            if (it % 500 == 0) rd_chk("R2 random enable readback", 'h10 + 4 * (it / 500 % ENW));
            if (it % 500 == 250) rd_chk("R3 random sense readback", 'h110 + 4 * int'($urandom % N));
        end

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule